// File: doc/BRIEF.md
# Programmable Chip-Select Window Decoder

This block maps system addresses onto eight external chip-selects. Each chip-select owns one configuration word, written and read over a simple 32-bit register port. The word holds an enable bit, a 6-bit base in 16 MB granules, and a 4-bit size mask. A window is 16, 32, 64 or 128 MB long. Inside a window the address aliases: only the address bits that the mask selects take part in the compare.

The block checks every configuration for legality. Only contiguous-ones mask codes are accepted, and the base must be aligned to the window size. A window drives its chip-select only when it is both enabled and legal. A write that enables an illegal window still stores the word, but it raises a one-cycle error strobe and leaves the window disabled. The decode output is registered and one-hot. When windows overlap, the lowest-numbered window wins.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, slot 0 reads 0x00000F40 (enabled, base 0, mask 4'b1111) and slots 1 to 7 read 0x00000F00.
- R2: Only bits 11:8 (mask), bit 6 (enable) and bits 5:0 (base) of a written word are stored. Every other bit of reg_rdata reads 0. The read is combinational on reg_sel.
- R3: Only mask codes 4'b1000, 4'b1100, 4'b1110 and 4'b1111 are legal, giving 128, 64, 32 and 16 MB windows. A window with any other mask never asserts its chip-select.
- R4: A window whose base bits 3:0 are set where the mask is 0 is misaligned, and it never asserts its chip-select.
- R5: An enabled, legal window with base B and mask M hits an address A exactly when A[31:30] is 0, A[29:28] equals B[5:4], and (A[27:24] XOR B[3:0]) AND M is 0. Addresses therefore alias every window-size bytes.
- R6: cs_sel has at most one bit set. Bit i is set only for the lowest-numbered window that hits.
- R7: A write with bit 6 set and an illegal mask or misaligned base pulses config_error high for exactly the one cycle after the write edge. The word is still stored. A legal write, or a write with bit 6 clear, leaves config_error low.
- R8: cs_sel is registered. After each clock edge it reflects the dec_addr and the configuration in force before that edge, so a write takes effect on the decode one edge later.
- R9: A window with bit 6 clear never asserts its chip-select, whatever its base and mask.
- R10: A write to one slot leaves the other slots' stored words and decode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the configuration word |
| reg_sel | input | 3 | Slot index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read of the selected slot |
| dec_addr | input | 32 | System address to decode |
| cs_sel | output | 8 | Registered one-hot chip-select |
| config_error | output | 1 | One-cycle pulse on an illegal enabling write |

## Verification
A wrong stored word shows on reg_rdata in the same cycle that slot is selected. A wrong enable or compare shows on cs_sel one edge after an address inside or outside the affected window is presented. A stale enable after a write that changes the window is caught by the decode of the very next address. A faulty legality check shows both on config_error in the cycle after the write and as a missing or extra chip-select on the next matching address.

// File: rtl/cswin_pkg.sv
package cswin_pkg;
  // writable portion of a configuration word
  localparam logic [31:0] CFG_WR_MASK = 32'h0000_0F7F;
  localparam int          EN_BIT      = 6;

  // contiguous-ones size codes only
  function automatic logic mask_ok(input logic [3:0] m);
    case (m)
      4'b1000, 4'b1100, 4'b1110, 4'b1111: mask_ok = 1'b1;
      default:                            mask_ok = 1'b0;
    endcase
  endfunction

  // legal code and base aligned to the window size
  function automatic logic win_legal(input logic [3:0] m, input logic [3:0] b);
    win_legal = mask_ok(m) && ((b & ~m) == 4'b0000);
  endfunction
endpackage

// File: rtl/cs_cfg_slot.sv
module cs_cfg_slot
  import cswin_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] RESET_VAL = 32'h0000_0F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg,
  output logic              enabled,
  output logic              bad_write
);
  localparam logic [DATA_W-1:0] WMASK = DATA_W'(CFG_WR_MASK);
  localparam logic [DATA_W-1:0] RVAL  = DATA_W'(RESET_VAL) & WMASK;

  logic changes;
  logic new_legal;

  assign changes   = ((cfg ^ wdata) & WMASK) != '0;
  assign new_legal = win_legal(wdata[11:8], wdata[3:0]);
  assign bad_write = wr_en && wdata[EN_BIT] && !new_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= RVAL;
      enabled <= RVAL[EN_BIT] && win_legal(RVAL[11:8], RVAL[3:0]);
    end else if (wr_en) begin
      cfg <= wdata & WMASK;
      // map is rebuilt only when a writable bit changes
      if (changes)
        enabled <= wdata[EN_BIT] && new_legal;
    end
  end

  // R3
  en_legal_chk: assert property (@(posedge clk) disable iff (rst)
    enabled |-> (cfg[EN_BIT] && win_legal(cfg[11:8], cfg[3:0])));

  // R10
  hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) && !$past(rst) |-> $stable(cfg));
endmodule

// File: rtl/cs_window_match.sv
module cs_window_match (
  input  logic       enabled,
  input  logic [5:0] base,
  input  logic [3:0] mask,
  input  logic [7:0] addr_hi,
  output logic       hit
);
  logic upper_eq;
  logic lower_eq;

  assign upper_eq = (addr_hi[7:4] == {2'b00, base[5:4]});
  assign lower_eq = (((addr_hi[3:0] ^ base[3:0]) & mask) == 4'b0000);
  assign hit      = enabled && upper_eq && lower_eq;
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // isolate lowest set bit
  assign grant = req & (~req + N'(1));
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswin_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic [$clog2(NUM_CS)-1:0] reg_sel,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [ADDR_W-1:0]         dec_addr,
  output logic [NUM_CS-1:0]         cs_sel,
  output logic                      config_error
);
  localparam int SEL_W = $clog2(NUM_CS);

  logic [DATA_W-1:0] cfg_q [NUM_CS];
  logic [NUM_CS-1:0] en_q;
  logic [NUM_CS-1:0] bad_w;
  logic [NUM_CS-1:0] hits;
  logic [NUM_CS-1:0] grant;
  logic [7:0]        addr_hi;

  assign addr_hi = dec_addr[ADDR_W-1 -: 8];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
    localparam logic [31:0] RV = (i == 0) ? 32'h0000_0F40 : 32'h0000_0F00;

    cs_cfg_slot #(.DATA_W(DATA_W), .RESET_VAL(RV)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (reg_we && (reg_sel == SEL_W'(i))),
      .wdata    (reg_wdata),
      .cfg      (cfg_q[i]),
      .enabled  (en_q[i]),
      .bad_write(bad_w[i])
    );

    cs_window_match u_match (
      .enabled(en_q[i]),
      .base   (cfg_q[i][5:0]),
      .mask   (cfg_q[i][11:8]),
      .addr_hi(addr_hi),
      .hit    (hits[i])
    );
  end

  cs_prio_pick #(.N(NUM_CS)) u_pick (
    .req  (hits),
    .grant(grant)
  );

  assign reg_rdata = cfg_q[reg_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sel       <= '0;
      config_error <= 1'b0;
    end else begin
      cs_sel       <= grant;
      config_error <= |bad_w;
    end
  end

  // R6
  one_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_sel));

  // R7
  err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    config_error |-> $past(reg_we));

  // R9
  cs_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && (cs_sel != '0) |-> ((cs_sel & $past(en_q)) != '0));
endmodule

// File: tb/cs_window_decoder_test.sv
`timescale 1ns/1ps
module cs_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] dec_addr;
  logic [7:0]  cs_sel;
  logic        config_error;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_cfg [8];
  logic [7:0]  m_en;

  always #10 clk = ~clk;

  cs_window_decoder uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_addr(dec_addr),
    .cs_sel(cs_sel), .config_error(config_error)
  );

  function automatic logic legal_f(input logic [31:0] w);
    logic [3:0] m = w[11:8];
    logic ok = (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF);
    return ok && ((w[3:0] & ~m) == 4'h0);
  endfunction

  function automatic logic [7:0] exp_sel(input logic [31:0] a);
    logic [7:0] r = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      if (m_en[i] && a[31:30] == 2'b00 && a[29:28] == m_cfg[i][5:4] &&
          (((a[27:24] ^ m_cfg[i][3:0]) & m_cfg[i][11:8]) == 4'h0))
        r = 8'h01 << i;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write one slot; checks error pulse after the edge
  task automatic wr(input logic [2:0] s, input logic [31:0] v);
    logic exp_err;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    exp_err = v[6] && !legal_f(v);
    @(posedge clk);
    if (((m_cfg[s] ^ v) & 32'h0F7F) != 0) m_en[s] = v[6] && legal_f(v);
    m_cfg[s] = v & 32'h0F7F;
    #1;
    check("R7 err", {31'b0, config_error}, {31'b0, exp_err});
    @(negedge clk);
    reg_we = 1'b0;
    check("R7 pulse", {31'b0, config_error}, {31'b0, exp_err});
    @(posedge clk); #1;
    check("R7 single", {31'b0, config_error}, 32'h0);
  endtask

  task automatic dec(input string req, input logic [31:0] a);
    @(negedge clk);
    dec_addr = a;
    @(posedge clk); #1;
    check(req, {24'b0, cs_sel}, {24'b0, exp_sel(a)});
  endtask

  task automatic rd(input string req, input logic [2:0] s);
    @(negedge clk);
    reg_sel = s; #1;
    check(req, reg_rdata, m_cfg[s]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    logic [31:0] old_exp;
    seed_dummy = $urandom(32'h5EED_0042);
    rst = 1'b1; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; dec_addr = '0;
    m_cfg[0] = 32'h0F40; m_en = 8'h01;
    for (int i = 1; i < 8; i++) m_cfg[i] = 32'h0F00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    for (int i = 0; i < 8; i++) rd("R1 reset", 3'(i));
    dec("R1 reset decode", 32'h00AB_CDEF);
    dec("R5 outside cs0", 32'h0100_0000);

    // R2 reserved bits dropped
    wr(3'd3, 32'hFFFF_FFFF);
    rd("R2 mask", 3'd3);
    dec("R2 decode", 32'h3F12_3456);

    // R4 misaligned base
    wr(3'd4, 32'h0000_0C53);
    rd("R4 stored", 3'd4);
    dec("R4 no hit", 32'h1300_0000);

    // R3 illegal mask
    wr(3'd5, 32'h0000_0550);
    dec("R3 no hit", 32'h1000_0000);

    // R5 alias 128MB window at 0x08000000
    wr(3'd1, 32'h0000_0848);
    dec("R5 alias in", 32'h0F00_0000);
    dec("R5 alias low", 32'h0800_0010);
    dec("R5 other page", 32'h1700_0000);
    dec("R5 top bits", 32'h4800_0000);

    // R6 overlap: cs2 same as cs0, cs0 wins
    wr(3'd2, 32'h0000_0F40);
    dec("R6 prio", 32'h0000_1000);

    // R9 disable cs0, cs2 takes over
    wr(3'd0, 32'h0000_0F00);
    dec("R9 cs0 off", 32'h0000_1000);
    rd("R10 cs2 kept", 3'd2);

    // R8 latency: write and address in same cycle
    @(negedge clk);
    old_exp = {24'b0, exp_sel(32'h2100_0000)};
    reg_we = 1'b1; reg_sel = 3'd6; reg_wdata = 32'h0000_0F61; dec_addr = 32'h2100_0000;
    @(posedge clk);
    m_cfg[6] = 32'h0F61; m_en[6] = 1'b1;
    #1;
    check("R8 old config", {24'b0, cs_sel}, old_exp);
    @(negedge clk); reg_we = 1'b0;
    @(posedge clk); #1;
    check("R8 new config", {24'b0, cs_sel}, {24'b0, exp_sel(32'h2100_0000)});

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] v, a;
      int pick;
      pick = $urandom_range(0, 2);
      if (pick == 0) begin
        v = $urandom;
        if ($urandom_range(0, 1) == 1) begin
          case ($urandom_range(0, 3))
            0: v[11:8] = 4'h8;
            1: v[11:8] = 4'hC;
            2: v[11:8] = 4'hE;
            default: v[11:8] = 4'hF;
          endcase
          v[3:0] = v[3:0] & v[11:8];
        end
        wr(3'($urandom_range(0, 7)), v);
      end else if (pick == 1) begin
        a = $urandom;
        if ($urandom_range(0, 3) != 0) a[31:30] = 2'b00;
        dec("R5 random", a);
      end else begin
        rd("R2 random", 3'($urandom_range(0, 7)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule